// File: doc/BRIEF.md
# CAM Occupancy Counter with Almost-Full Alarm

This block keeps the occupancy figures for a content-addressable table and the entry queue in front of it. Single-cycle pulses tell it when an entry lands in the table directly, when a table entry is removed, when an insert is parked in the queue, and when a parked insert drains into the table. From these pulses it keeps two counts: the entries in the table and the inserts still waiting in the queue.

A small command port takes two operations. One loads a programmable threshold from the low bits of a 16-bit data word. The other returns the total occupancy, which is the table count plus the waiting inserts, on a one-cycle response strobe. A sticky alarm flag is set when an insert brings the table-only count to exactly the threshold. Queued inserts do not affect the alarm. The flag drives an interrupt line through an enable input, and software clears it. The threshold can be rewritten at any time, so software can raise it in steps, for example from half full to three-quarters full.

Top module: `cam_occ_monitor`

## Requirements
- R1: After synchronous reset, both counts are 0, the threshold is 0, and af_flag_o, irq_o and cnt_vld_o are 0.
- R2: The table count rises by one for each tbl_ins_i pulse and for each accepted q_drain_i pulse, and falls by one for each tbl_del_i pulse, all in the same clock. It saturates at 0 and at DEPTH (4096).
- R3: The pending count rises by one on q_ins_i and falls by one on q_drain_i. A q_drain_i pulse is ignored entirely while the pending count is 0, so the table count does not change either. A q_ins_i pulse is ignored while the pending count equals QDEPTH (16).
- R4: When cmd_valid_i is high and cmd_op_i is 0, the threshold is loaded from cmd_data_i[11:0] and bits 15:12 are ignored. The new value takes effect from the next cycle.
- R5: In a cycle with at least one table insert (tbl_ins_i or an accepted q_drain_i), if the updated table count equals the threshold, af_flag_o is 1 after that edge. A q_ins_i pulse alone never sets the flag, whatever the total occupancy.
- R6: A cycle without a table insert never sets af_flag_o, even when a delete brings the table count to the threshold.
- R7: af_flag_o stays set until af_clr_i is high. If a set condition and af_clr_i arrive in the same cycle, the set wins.
- R8: After each edge, irq_o equals the new af_flag_o AND irq_en_i as sampled at that edge.
- R9: When cmd_valid_i is high and cmd_op_i is 1, cnt_vld_o is 1 in the next cycle. In that cycle cnt_data_o holds the table count plus the pending count as they stood during the request cycle. cnt_vld_o is 0 in all other cycles.
- R10: After the alarm fires, software can load a higher threshold and clear the flag, and a later insert that reaches the new threshold sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_ins_i | input | 1 | One entry written directly to the table |
| tbl_del_i | input | 1 | One entry removed from the table |
| q_ins_i | input | 1 | One insert placed in the queue |
| q_drain_i | input | 1 | One queued insert moved into the table |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 1 | 0 = load threshold, 1 = request count |
| cmd_data_i | input | 16 | Command data; bits 11:0 are the threshold |
| irq_en_i | input | 1 | Interrupt enable for the alarm |
| af_clr_i | input | 1 | Clears the alarm flag |
| cnt_vld_o | output | 1 | Count response strobe |
| cnt_data_o | output | 16 | Total occupancy (table + pending) |
| af_flag_o | output | 1 | Sticky almost-full alarm flag |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
A vector table applies single and combined pulses to the four count inputs. It includes delete plus insert together, insert plus drain together, all four at once, and a drain on an empty queue. A count query after each vector separates correct net arithmetic from a counter that loses simultaneous events or takes an empty-queue drain as a table insert. Directed sequences show that the alarm follows the table-only count and not the total. They also cover these cases: a delete that lands on the threshold does not fire the alarm, set beats clear, a drain can trigger the alarm, the threshold can be raised, and the interrupt follows its enable. Long runs of inserts and deletes test saturation at both ends of each counter.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic {
    OP_SET_THR = 1'b0,
    OP_GET_CNT = 1'b1
  } occ_op_e;
endpackage

// File: rtl/occ_tbl_cnt.sv
module occ_tbl_cnt #(
  parameter int DEPTH = 4096,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_a,
  input  logic             add_b,
  input  logic             sub,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             ins_evt
);
  localparam int WIDE_W = CNT_W + 2;
  localparam logic [WIDE_W-1:0] LIMIT = WIDE_W'(DEPTH);

  logic [WIDE_W-1:0] wide_up;
  logic [WIDE_W-1:0] wide_net;

  always_comb begin
    wide_up = {2'b00, cnt_q} + WIDE_W'(add_a) + WIDE_W'(add_b);
    if (sub && wide_up != '0) wide_net = wide_up - WIDE_W'(1);
    else                      wide_net = wide_up;
    if (wide_net > LIMIT) cnt_nxt = CNT_W'(DEPTH);
    else                  cnt_nxt = wide_net[CNT_W-1:0];
  end

  assign ins_evt = add_a | add_b;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // R2: the table count stays within 0..DEPTH
  p_tbl_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
  // R2: the count holds when no pulse arrives
  p_tbl_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!add_a && !add_b && !sub) |=> $stable(cnt_q));
endmodule

// File: rtl/occ_pend_cnt.sv
module occ_pend_cnt #(
  parameter int QDEPTH = 16,
  localparam int PW = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic          pop_ok,
  output logic [PW-1:0] pend_q
);
  logic push_ok;

  assign pop_ok  = pop  && (pend_q != '0);
  assign push_ok = push && (pend_q != PW'(QDEPTH));

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else if (push_ok && !pop_ok) pend_q <= pend_q + PW'(1);
    else if (pop_ok && !push_ok) pend_q <= pend_q - PW'(1);
  end

  // R3: the pending count never exceeds the queue depth
  p_pend_bound_r3: assert property (@(posedge clk) disable iff (rst)
    pend_q <= PW'(QDEPTH));
  // R3: a drain on an empty queue is ignored
  p_pend_empty_r3: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0 && !push) |=> pend_q == '0);
endmodule

// File: rtl/occ_alarm.sv
module occ_alarm #(
  parameter int THR_W = 12,
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_din,
  input  logic             ins_evt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             clr,
  input  logic             irq_en,
  output logic             flag_q,
  output logic             irq_q
);
  logic [THR_W-1:0] thr_q;
  logic             hit;
  logic             flag_d;

  assign hit    = ins_evt && (cnt_nxt == CNT_W'(thr_q));
  assign flag_d = hit || (flag_q && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (thr_we) thr_q <= thr_din;
      flag_q <= flag_d;
      irq_q  <= flag_d && irq_en;
    end
  end

  // R4: a threshold write lands on the next edge
  p_thr_load_r4: assert property (@(posedge clk) disable iff (rst)
    thr_we |=> thr_q == $past(thr_din));
  // R5: an insert reaching the threshold sets the flag
  p_alarm_set_r5: assert property (@(posedge clk) disable iff (rst)
    (ins_evt && cnt_nxt == CNT_W'(thr_q)) |=> flag_q);
  // R6: no insert, no new alarm
  p_no_set_wo_ins_r6: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !ins_evt) |=> !flag_q);
  // R7: flag is sticky until cleared
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  // R8: interrupt only with the flag set
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
endmodule

// File: rtl/occ_report.sv
module occ_report #(
  parameter int CNT_W  = 13,
  parameter int PW     = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [CNT_W-1:0]  tbl_cnt,
  input  logic [PW-1:0]     pend_cnt,
  output logic              vld_q,
  output logic [DATA_W-1:0] data_q
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0]  total;
  logic [DATA_W-1:0] total_fit;

  assign total = SUM_W'(tbl_cnt) + SUM_W'(pend_cnt);

  generate
    if (DATA_W >= SUM_W) begin : g_pad
      assign total_fit = DATA_W'(total);
    end else begin : g_cut
      assign total_fit = total[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= req;
      if (req) data_q <= total_fit;
    end
  end

  // R9: a response follows each request and nothing else
  p_resp_r9: assert property (@(posedge clk) disable iff (rst)
    req |=> vld_q);
  p_no_resp_r9: assert property (@(posedge clk) disable iff (rst)
    !req |=> !vld_q);
endmodule

// File: rtl/cam_occ_monitor.sv
module cam_occ_monitor #(
  parameter int DEPTH  = 4096,
  parameter int QDEPTH = 16,
  parameter int THR_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_ins_i,
  input  logic              tbl_del_i,
  input  logic              q_ins_i,
  input  logic              q_drain_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              irq_en_i,
  input  logic              af_clr_i,
  output logic              cnt_vld_o,
  output logic [DATA_W-1:0] cnt_data_o,
  output logic              af_flag_o,
  output logic              irq_o
);
  import occ_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PW    = $clog2(QDEPTH + 1);

  logic             drain_ok;
  logic [PW-1:0]    pend_cnt;
  logic [CNT_W-1:0] tbl_cnt;
  logic [CNT_W-1:0] tbl_nxt;
  logic             ins_evt;
  logic             thr_we;
  logic             cnt_req;
  logic             unused_hi;

  assign thr_we    = cmd_valid_i && (occ_op_e'(cmd_op_i) == OP_SET_THR);
  assign cnt_req   = cmd_valid_i && (occ_op_e'(cmd_op_i) == OP_GET_CNT);
  assign unused_hi = ^cmd_data_i[DATA_W-1:THR_W];

  occ_pend_cnt #(.QDEPTH(QDEPTH)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .push   (q_ins_i),
    .pop    (q_drain_i),
    .pop_ok (drain_ok),
    .pend_q (pend_cnt)
  );

  occ_tbl_cnt #(.DEPTH(DEPTH)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .add_a   (tbl_ins_i),
    .add_b   (drain_ok),
    .sub     (tbl_del_i),
    .cnt_q   (tbl_cnt),
    .cnt_nxt (tbl_nxt),
    .ins_evt (ins_evt)
  );

  occ_alarm #(.THR_W(THR_W), .CNT_W(CNT_W)) u_alarm (
    .clk     (clk),
    .rst     (rst),
    .thr_we  (thr_we),
    .thr_din (cmd_data_i[THR_W-1:0]),
    .ins_evt (ins_evt),
    .cnt_nxt (tbl_nxt),
    .clr     (af_clr_i),
    .irq_en  (irq_en_i),
    .flag_q  (af_flag_o),
    .irq_q   (irq_o)
  );

  occ_report #(.CNT_W(CNT_W), .PW(PW), .DATA_W(DATA_W)) u_rep (
    .clk      (clk),
    .rst      (rst),
    .req      (cnt_req),
    .tbl_cnt  (tbl_cnt),
    .pend_cnt (pend_cnt),
    .vld_q    (cnt_vld_o),
    .data_q   (cnt_data_o)
  );

  // R1: everything idle in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!af_flag_o && !irq_o && !cnt_vld_o));
endmodule

// File: tb/cam_occ_monitor_tb.sv
module cam_occ_monitor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_ins = 0, tbl_del = 0, q_ins = 0, q_drain = 0;
  logic        cmd_valid = 0, cmd_op = 0;
  logic [15:0] cmd_data = '0;
  logic        irq_en = 0, af_clr = 0;
  logic        cnt_vld, af_flag, irq;
  logic [15:0] cnt_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cam_occ_monitor u_dut (
    .clk(clk), .rst(rst), .tbl_ins_i(tbl_ins), .tbl_del_i(tbl_del),
    .q_ins_i(q_ins), .q_drain_i(q_drain), .cmd_valid_i(cmd_valid),
    .cmd_op_i(cmd_op), .cmd_data_i(cmd_data), .irq_en_i(irq_en),
    .af_clr_i(af_clr), .cnt_vld_o(cnt_vld), .cnt_data_o(cnt_data),
    .af_flag_o(af_flag), .irq_o(irq)
  );

  // {ins, del, qins, qdrain, expected total after}
  localparam logic [19:0] VEC [15] = '{
    {4'b1000, 16'd1}, {4'b1000, 16'd2}, {4'b0010, 16'd3}, {4'b0010, 16'd4},
    {4'b0001, 16'd4}, {4'b0100, 16'd3}, {4'b1100, 16'd3}, {4'b1001, 16'd4},
    {4'b0001, 16'd4}, {4'b0011, 16'd5}, {4'b0100, 16'd4}, {4'b0010, 16'd5},
    {4'b0011, 16'd6}, {4'b0100, 16'd5}, {4'b1111, 16'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic i, input logic d, input logic qi, input logic qd);
    tbl_ins = i; tbl_del = d; q_ins = qi; q_drain = qd;
    @(negedge clk);
    tbl_ins = 0; tbl_del = 0; q_ins = 0; q_drain = 0;
  endtask

  task automatic query(input string req, input logic [15:0] exp);
    cmd_valid = 1; cmd_op = 1;
    @(negedge clk);
    cmd_valid = 0;
    check({req, " vld"}, 32'(cnt_vld), 32'd1);
    check({req, " data"}, 32'(cnt_data), 32'(exp));
  endtask

  task automatic set_thr(input logic [15:0] d);
    cmd_valid = 1; cmd_op = 0; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 flag", 32'(af_flag), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 vld", 32'(cnt_vld), 32'd0);
    rst = 0;
    @(negedge clk);
    check("R9 no request", 32'(cnt_vld), 32'd0);
    query("R1 count", 16'd0);

    // vector walk: R2 R3 R9
    for (int k = 0; k < 15; k++) begin
      pulse(VEC[k][19], VEC[k][18], VEC[k][17], VEC[k][16]);
      query($sformatf("R2/R3 vec%0d", k), VEC[k][15:0]);
    end
    check("R6 no alarm at thr 0", 32'(af_flag), 32'd0);

    // alarm uses table-only count: R4 R5 R8
    do_reset();
    irq_en = 1;
    set_thr(16'hF003);
    pulse(1, 0, 0, 0);
    pulse(1, 0, 0, 0);
    pulse(0, 0, 1, 0);
    check("R5 queue excluded", 32'(af_flag), 32'd0);
    pulse(1, 0, 0, 0);
    check("R4/R5 flag at thr", 32'(af_flag), 32'd1);
    check("R8 irq on", 32'(irq), 32'd1);
    repeat (3) @(negedge clk);
    check("R7 sticky", 32'(af_flag), 32'd1);
    af_clr = 1; @(negedge clk); af_clr = 0;
    check("R7 cleared", 32'(af_flag), 32'd0);
    check("R8 irq cleared", 32'(irq), 32'd0);

    // delete landing on threshold: R6 (T=3, Q=1)
    set_thr(16'd2);
    pulse(0, 1, 0, 0);
    check("R6 delete no alarm", 32'(af_flag), 32'd0);

    // raise threshold: R10 (T=2)
    set_thr(16'd4);
    pulse(1, 0, 0, 0);
    check("R10 below new thr", 32'(af_flag), 32'd0);
    pulse(1, 0, 0, 0);
    check("R10 new thr fires", 32'(af_flag), 32'd1);
    irq_en = 0; @(negedge clk);
    check("R8 irq masked", 32'(irq), 32'd0);
    check("R8 flag kept", 32'(af_flag), 32'd1);

    // set beats clear: R7 (T=4)
    irq_en = 1;
    set_thr(16'd5);
    af_clr = 1; tbl_ins = 1;
    @(negedge clk);
    af_clr = 0; tbl_ins = 0;
    check("R7 set wins", 32'(af_flag), 32'd1);

    // drain triggers alarm: R5 (T=5, Q=1)
    set_thr(16'd6);
    af_clr = 1; @(negedge clk); af_clr = 0;
    pulse(0, 0, 0, 1);
    check("R5 drain fires", 32'(af_flag), 32'd1);
    query("R9 total", 16'd6);

    // saturation: R2 R3
    do_reset();
    tbl_ins = 1;
    repeat (4100) @(negedge clk);
    tbl_ins = 0;
    query("R2 top sat", 16'd4096);
    do_reset();
    pulse(0, 1, 0, 0);
    query("R2 bottom sat", 16'd0);
    q_ins = 1;
    repeat (20) @(negedge clk);
    q_ins = 0;
    query("R3 queue sat", 16'd16);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule